// File: doc/BRIEF.md
# Sample-ROM Playback Address Sequencer

This block drives the read address of a 64 KB sample ROM for one compressed-audio effect channel. A host writes a first address and a last address, then releases the channel. From then on a divider derived from the system clock produces one sample tick every `TICK_DIV` cycles (48 by default, so a 375 kHz clock yields 7812.5 Hz). On each tick the block raises a one-cycle sample strobe with the address valid in that same cycle, then steps the address by one. When the strobe has presented the last address, the block stops, holds that address, and reasserts the decoder reset.

The normal host sequence is: hold the channel, which asserts the decoder reset; load the first address; load the last address; then release the channel. While the channel is held, no strobes are issued and the address does not move. Writing a new first address while the channel plays makes that address the one shown by the next strobe, without disturbing the tick cadence.

Top module: `sample_addr_seq`

## Requirements
- R1: After reset `dec_rst` is 1, `smp_stb` is 0 and `rom_addr` is 0.
- R2: While `dec_rst` is 1, `smp_stb` stays 0 and `rom_addr` changes only through a first-address write.
- R3: After a release write accepted in cycle 0, the first strobe comes in cycle `TICK_DIV`, and later strobes follow exactly `TICK_DIV` cycles apart.
- R4: A first-address write (`wr_start`) puts `wr_data` on `rom_addr` in the next cycle; successive strobes then present that address and each following address in turn, counting modulo 2^16.
- R5: The strobe that presents an address equal to the stored last address is the final one: from the next cycle `dec_rst` is 1 and `rom_addr` holds the last address, so a span from A to B yields ((B-A) mod 2^16)+1 strobes.
- R6: A first-address write while playing makes the next strobe present the new address, at the unchanged cadence, and counting continues from it.
- R7: A hold write (`wr_hold`) asserts `dec_rst` in the next cycle and stops all further strobes.
- R8: When `wr_hold` and `wr_release` are high in the same cycle, hold wins and the channel stays stopped.
- R9: A last-address write (`wr_end`) while playing takes effect for the stop decision at the following strobes.
- R10: When the first and last addresses are equal, a release yields exactly one strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_start | input | 1 | One-cycle strobe: load `wr_data` as the first address and the current address |
| wr_end | input | 1 | One-cycle strobe: load `wr_data` as the last address |
| wr_hold | input | 1 | One-cycle strobe: stop playback and assert the decoder reset |
| wr_release | input | 1 | One-cycle strobe: start playback |
| wr_data | input | ADDR_W | Data for the address writes |
| rom_addr | output | ADDR_W | Current sample-ROM address |
| smp_stb | output | 1 | One-cycle sample strobe; `rom_addr` is valid in this cycle |
| dec_rst | output | 1 | Decoder reset, high while the channel is stopped |

## Verification
The bench sweeps spans of every length from one to sixteen addresses from many starting points, including one that wraps past 0xFFFF, and computes the expected strobe cycle and address for each tick arithmetically; a design that incremented before the first strobe, stopped one address early or late, or let the address wrap past the last value would show a wrong address or a wrong strobe count. Restarting mid-play and moving the last address mid-play are checked against the tick cadence, catching a design that resets the divider on a load or compares against a stale bound. Simultaneous hold and release, and hold during playback, are checked for strobes leaking after the stop.

// File: rtl/sample_addr_seq.sv
module sample_addr_seq #(
  parameter int ADDR_W   = 16,
  parameter int TICK_DIV = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_start,
  input  logic              wr_end,
  input  logic              wr_hold,
  input  logic              wr_release,
  input  logic [ADDR_W-1:0] wr_data,
  output logic [ADDR_W-1:0] rom_addr,
  output logic              smp_stb,
  output logic              dec_rst
);
  localparam int DW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(TICK_DIV - 1);

  logic [DW-1:0]     div_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] end_q;
  logic              run_q;
  logic              tick;
  logic              at_end;

  assign tick   = run_q && (div_q == DIV_LAST);
  assign at_end = (addr_q == end_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      div_q  <= '0;
      addr_q <= '0;
      end_q  <= '0;
    end else begin
      if (wr_hold)              run_q <= 1'b0;
      else if (tick && at_end)  run_q <= 1'b0;
      else if (wr_release)      run_q <= 1'b1;

      if (!run_q || tick) div_q <= '0;
      else                div_q <= div_q + 1'b1;

      if (wr_start)            addr_q <= wr_data;
      else if (tick && !at_end) addr_q <= addr_q + 1'b1;

      if (wr_end) end_q <= wr_data;
    end
  end

  assign rom_addr = addr_q;
  assign smp_stb  = tick;
  assign dec_rst  = !run_q;

  always_comb begin
    if (rst_n) assert (div_q < TICK_DIV) else $error("divider out of range");
  end

  p_held_addr_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_rst && !wr_start) |=> $stable(rom_addr));

  p_stb_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb |=> !smp_stb);

  p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start |=> (rom_addr == $past(wr_data)));

  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_stb && (rom_addr != end_q) && !wr_start) |=> (rom_addr == $past(rom_addr) + 1'b1));

  p_stop_at_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_stb && (rom_addr == end_q)) |=> dec_rst);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hold |=> (dec_rst && !smp_stb));
endmodule

// File: tb/test_sample_addr_seq.sv
module test_sample_addr_seq;
  localparam int DIV = 6;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_start = 1'b0, wr_end = 1'b0, wr_hold = 1'b0, wr_release = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rom_addr;
  logic smp_stb, dec_rst;
  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  sample_addr_seq #(.ADDR_W(16), .TICK_DIV(DIV)) i_sample_addr_seq (
    .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .wr_end(wr_end),
    .wr_hold(wr_hold), .wr_release(wr_release), .wr_data(wr_data),
    .rom_addr(rom_addr), .smp_stb(smp_stb), .dec_rst(dec_rst));

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input int kind, input logic [15:0] d);
    wr_data = d;
    case (kind)
      0: wr_start = 1'b1;
      1: wr_end = 1'b1;
      2: wr_hold = 1'b1;
      3: wr_release = 1'b1;
      default: begin wr_hold = 1'b1; wr_release = 1'b1; end
    endcase
    step();
    wr_start = 1'b0; wr_end = 1'b0; wr_hold = 1'b0; wr_release = 1'b0;
  endtask

  task automatic wait_stb(input logic [15:0] exp_a, input int gap, input string req);
    int n = 0;
    while (!smp_stb && n <= DIV + 1) begin step(); n++; end
    chk(smp_stb, req, {31'd0, smp_stb}, 32'd1);
    chk(rom_addr == exp_a, req, {16'd0, rom_addr}, {16'd0, exp_a});
    if (gap > 0) chk(n == gap, {req, " cadence"}, n, gap);
    step();
  endtask

  task automatic quiet(input int cycles, input logic [15:0] exp_a, input string req);
    for (int i = 0; i < cycles; i++) begin
      chk(!smp_stb && dec_rst, req, {30'd0, smp_stb, dec_rst}, 32'd1);
      chk(rom_addr == exp_a, req, {16'd0, rom_addr}, {16'd0, exp_a});
      step();
    end
  endtask

  task automatic play(input logic [15:0] s, input logic [15:0] e);
    logic [15:0] span;
    int n;
    wr(2, 16'h0);
    wr(0, s);
    chk(rom_addr == s, "R4 load", {16'd0, rom_addr}, {16'd0, s});
    chk(dec_rst, "R2 held", {31'd0, dec_rst}, 32'd1);
    wr(1, e);
    wr(3, 16'h0);
    span = e - s;
    n = int'(span) + 1;
    for (int i = 1; i <= n * DIV + 2 * DIV; i++) begin
      bit exp_stb;
      exp_stb = (i % DIV == 0) && (i / DIV <= n);
      chk(smp_stb == exp_stb, "R3 R5 strobe timing", {31'd0, smp_stb}, {31'd0, exp_stb});
      if (exp_stb) begin
        logic [15:0] ea;
        ea = s + 16'(i / DIV - 1);
        chk(rom_addr == ea, "R4 address", {16'd0, rom_addr}, {16'd0, ea});
      end
      step();
    end
    chk(dec_rst, "R5 stopped", {31'd0, dec_rst}, 32'd1);
    chk(rom_addr == e, "R5 hold last", {16'd0, rom_addr}, {16'd0, e});
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    step(); step();
    rst_n = 1'b1;
    step();
    chk(dec_rst, "R1 dec_rst", {31'd0, dec_rst}, 32'd1);
    chk(!smp_stb, "R1 smp_stb", {31'd0, smp_stb}, 32'd0);
    chk(rom_addr == 16'h0, "R1 rom_addr", {16'd0, rom_addr}, 32'd0);
    quiet(2 * DIV, 16'h0, "R2 idle after reset");

    // R10 single-address span
    play(16'h0040, 16'h0040);
    // sweep of span lengths and starting points, one wrapping past 0xFFFF
    for (int len = 0; len < 16; len++) play(16'(len * 16'h1111 + 3), 16'(len * 16'h1111 + 3 + len));
    play(16'hFFF9, 16'h0004);
    play(16'h1234, 16'h1240);

    // R6 restart from a new first address while playing
    wr(2, 0); wr(0, 16'h0100); wr(1, 16'h0505); wr(3, 0);
    wait_stb(16'h0100, DIV - 1, "R6 first");
    wait_stb(16'h0101, DIV - 1, "R6 second");
    step();
    wr(0, 16'h0500);
    chk(!dec_rst, "R6 still playing", {31'd0, dec_rst}, 32'd0);
    wait_stb(16'h0500, DIV - 3, "R6 restarted");
    for (int k = 1; k <= 5; k++) wait_stb(16'(16'h0500 + k), DIV - 1, "R6 continue");
    quiet(2 * DIV, 16'h0505, "R6 R5 stop after restart");

    // R9 move the last address while playing
    wr(2, 0); wr(0, 16'h0020); wr(1, 16'h0040); wr(3, 0);
    wait_stb(16'h0020, DIV - 1, "R9 a");
    wait_stb(16'h0021, DIV - 1, "R9 b");
    wr(1, 16'h0024);
    for (int k = 2; k <= 4; k++) wait_stb(16'(16'h0020 + k), 0, "R9 new bound");
    quiet(2 * DIV, 16'h0024, "R9 stopped at new bound");

    // R7 hold during playback
    wr(2, 0); wr(0, 16'h0300); wr(1, 16'h03FF); wr(3, 0);
    wait_stb(16'h0300, DIV - 1, "R7 a");
    step();
    wr(2, 0);
    quiet(3 * DIV, 16'h0301, "R7 hold stops");

    // R8 hold and release together while held, then while playing
    wr(4, 0);
    quiet(3 * DIV, 16'h0301, "R8 held");
    wr(3, 0);
    wait_stb(16'h0301, DIV - 1, "R8 resumed");
    wr(4, 0);
    quiet(3 * DIV, 16'h0302, "R8 hold wins");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule